// File: doc/BRIEF.md
# Cold Reset Generator with Stall Timer

This block merges three cold reset causes into a single chip-wide power-on reset. The causes are an active-low power-on pin, an emulation power-on request and a software request bit. The reset asserts at once when any cause becomes active. It is held until three conditions are met: every cause has gone away, the supply rails report good, and the reference clock reports stable. A programmable stall counter, clocked by the always-on reference clock, then runs to its limit, and only after that does the reset release. Because the release is timed by that clock, the reset can never release while the clock is stopped.

The block also drives a sticky secure-mode flag. An emulation power-on request sets the flag without waiting for a clock edge. Only the power-on pin clears it. Software reaches the block through a small register port. A write port with valid/ready handshake accepts register writes; ready is tied high, so the port never applies back-pressure and a write completes in any cycle where valid is high. A combinational read port returns the addressed register.

Top module: `cold_rst_gen`

## Requirements
- R1: The reset output `glob_rst_o` is high whenever `por_n_i` is low, `emu_por_i` is high or a software request is pending. Both pin causes raise it without waiting for a clock edge.
- R2: A release waits until all causes are inactive and both `rails_ok_i` and `clk_stable_i` are high. Each of these conditions passes through its own two-stage synchroniser.
- R3: Let N be the value of the stall register. With both flags already high, the reset falls N+3 clock edges after the last cause clears. If a flag rises last, the reset falls N+3 edges after that flag rises. If the stall register is lowered below the current count, the release happens on the next edge.
- R4: If either flag drops, the reset is high again by the third edge after the drop and the stall count restarts from zero. This applies both during counting and after release.
- R5: Writing a 1 to bit 0 of address 0 raises a software request that lasts one cycle and then clears itself. The reset then falls N+4 edges after the write edge. Writing a 0 to that bit has no effect.
- R6: Reading bit 0 of address 0 returns 1 from the write edge of a software request until the edge that releases the reset, and 0 otherwise.
- R7: Address 1 holds the 8-bit stall value. It resets to 12, only the power-on pin resets it, and it keeps its value through software and emulation resets.
- R8: `secure_o` rises when `emu_por_i` rises, without waiting for a clock edge. It stays high until `por_n_i` goes low. While `por_n_i` is low, `secure_o` is 0.
- R9: While the reference clock has no rising edges, the reset stays asserted.
- R10: `wr_ready_o` is always 1. A write is taken on every edge where `wr_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon_i | input | 1 | Always-on reference clock |
| por_n_i | input | 1 | External power-on pin, active low |
| emu_por_i | input | 1 | Emulation power-on request, active high |
| rails_ok_i | input | 1 | All supply rails at operating level |
| clk_stable_i | input | 1 | Reference clock running and stable |
| wr_valid_i | input | 1 | Register write valid |
| wr_ready_o | output | 1 | Register write ready (constant 1) |
| wr_addr_i | input | 1 | Write address: 0 control, 1 stall value |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 8 | Read data for rd_addr_i |
| glob_rst_o | output | 1 | Global power-on reset, active high |
| secure_o | output | 1 | Sticky secure-mode indicator |

## Verification
Two events can land on the same edge. One is a write that changes the stall limit or issues a software request. The other is the count reaching the release point. The bench provokes this by lowering the limit from 200 to 2 while a long count is under way, and expects the release on the very next edge. It also confirms that the busy readback clears on that same edge. A second overlap arises when an emulation request arrives while the secure flag and the reset are both already controlled by the pin. The bench judges this by checking both outputs before any clock edge follows the request.

// File: rtl/cold_rst_pkg.sv
package cold_rst_pkg;
  localparam int unsigned REG_AW = 1;
  localparam logic [REG_AW-1:0] ADDR_CTRL  = 1'b0;
  localparam logic [REG_AW-1:0] ADDR_STALL = 1'b1;
  localparam int unsigned CTRL_SW_BIT = 0;

  typedef struct packed {
    logic rails;
    logic clk_ok;
  } qual_t;
endpackage

// File: rtl/crg_sync.sv
module crg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) stg[i] <= '0;
          else         stg[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) stg[i] <= '0;
          else         stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/crg_stall.sv
module crg_stall #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          qual_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o,
  output logic          rel_o
);
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          hit;

  assign hit = (cnt_q >= limit_i);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!qual_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (hit) done_q <= 1'b1;
      else     cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
  assign rel_o  = qual_i && !done_q && hit;

  // R4
  qual_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !qual_i |=> !done_q);
endmodule

// File: rtl/crg_regs.sv
module crg_regs import cold_rst_pkg::*; #(
  parameter int unsigned DW        = 8,
  parameter int unsigned STALL_DEF = 12
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_valid_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              rel_i,
  output logic              sw_req_o,
  output logic              busy_o,
  output logic [DW-1:0]     limit_o
);
  logic          sw_req_q, busy_q;
  logic [DW-1:0] limit_q;
  logic          sw_hit;

  assign sw_hit = wr_valid_i && (wr_addr_i == ADDR_CTRL) && wr_data_i[CTRL_SW_BIT];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sw_req_q <= 1'b0;
      busy_q   <= 1'b0;
      limit_q  <= DW'(STALL_DEF);
    end else begin
      sw_req_q <= sw_hit;
      if (sw_hit)     busy_q <= 1'b1;
      else if (rel_i) busy_q <= 1'b0;
      if (wr_valid_i && (wr_addr_i == ADDR_STALL)) limit_q <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_STALL) rd_data_o = limit_q;
    else                         rd_data_o[CTRL_SW_BIT] = busy_q;
  end

  assign sw_req_o = sw_req_q;
  assign busy_o   = busy_q;
  assign limit_o  = limit_q;

  // R5
  sw_selfclr_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sw_req_q && !sw_hit) |=> !sw_req_q);
endmodule

// File: rtl/cold_rst_gen.sv
module cold_rst_gen import cold_rst_pkg::*; #(
  parameter int unsigned STALL_W       = 8,
  parameter int unsigned STALL_DEFAULT = 12,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic               clk_aon_i,
  input  logic               por_n_i,
  input  logic               emu_por_i,
  input  logic               rails_ok_i,
  input  logic               clk_stable_i,
  input  logic               wr_valid_i,
  output logic               wr_ready_o,
  input  logic [REG_AW-1:0]  wr_addr_i,
  input  logic [STALL_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0]  rd_addr_i,
  output logic [STALL_W-1:0] rd_data_o,
  output logic               glob_rst_o,
  output logic               secure_o
);
  logic               sw_req, busy, rel, done;
  logic [STALL_W-1:0] limit;
  logic               src_any, arst_n, src_clear;
  qual_t              qual_raw, qual_s;
  logic               qual_all;
  logic               secure_q;

  assign wr_ready_o = 1'b1;

  crg_regs #(.DW(STALL_W), .STALL_DEF(STALL_DEFAULT)) u_regs (
    .clk(clk_aon_i), .por_n(por_n_i),
    .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .rel_i(rel), .sw_req_o(sw_req), .busy_o(busy), .limit_o(limit)
  );

  assign src_any = !por_n_i || emu_por_i || sw_req;
  assign arst_n  = !src_any;

  crg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_src_sync (
    .clk(clk_aon_i), .arst_n(arst_n), .d(1'b1), .q(src_clear)
  );

  assign qual_raw = '{rails: rails_ok_i, clk_ok: clk_stable_i};

  crg_sync #(.W($bits(qual_t)), .STAGES(SYNC_STAGES)) u_qual_sync (
    .clk(clk_aon_i), .arst_n(arst_n), .d(qual_raw), .q(qual_s)
  );

  assign qual_all = src_clear && qual_s.rails && qual_s.clk_ok;

  crg_stall #(.CW(STALL_W)) u_stall (
    .clk(clk_aon_i), .arst_n(arst_n), .qual_i(qual_all),
    .limit_i(limit), .done_o(done), .rel_o(rel)
  );

  assign glob_rst_o = !done;

  always_ff @(posedge clk_aon_i or negedge por_n_i or posedge emu_por_i) begin
    if (!por_n_i)       secure_q <= 1'b0;
    else if (emu_por_i) secure_q <= 1'b1;
  end
  assign secure_o = secure_q;

  // R1
  src_forces_rst_chk: assert property (@(posedge clk_aon_i) disable iff (!por_n_i)
    (emu_por_i || sw_req) |-> glob_rst_o);

  // R2
  release_qual_chk: assert property (@(posedge clk_aon_i) disable iff (!arst_n)
    $fell(glob_rst_o) |-> ($past(rails_ok_i, 3) && $past(clk_stable_i, 3)));

  // R6
  busy_in_rst_chk: assert property (@(posedge clk_aon_i) disable iff (!por_n_i)
    busy |-> glob_rst_o);

  // R8
  secure_set_chk: assert property (@(posedge clk_aon_i) disable iff (!por_n_i)
    emu_por_i |-> secure_o);

  // R8
  secure_hold_chk: assert property (@(posedge clk_aon_i) disable iff (!por_n_i)
    $past(secure_o) |-> secure_o);
endmodule

// File: tb/sim_cold_rst_gen.sv
`timescale 1ns/1ps
module sim_cold_rst_gen;
  logic clk = 1'b0, clk_run = 1'b1;
  logic por_n, emu, rails, clkst, wr_valid, wr_ready, wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic glob, secure;
  int checks = 0, fails = 0;
  bit finished = 0;

  always begin #2; if (clk_run) clk = ~clk; end

  cold_rst_gen u0 (
    .clk_aon_i(clk), .por_n_i(por_n), .emu_por_i(emu), .rails_ok_i(rails),
    .clk_stable_i(clkst), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .glob_rst_o(glob), .secure_o(secure)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic wait_rel(input int lim, output int k);
    k = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk); k++;
      if (!glob) break;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    chk(glob == 1, "R1 reset during pin low", glob, 1);
    chk(secure == 0, "R8 secure clear under pin", secure, 0);
    chk(wr_ready == 1, "R10 ready", wr_ready, 1);
    rd(1'b1, v); chk(v == 12, "R7 stall default", v, 12);
    rd(1'b0, v); chk(v == 0, "R6 idle busy", v, 0);
  endtask

  task automatic t_por_release;
    int k;
    por_n = 1; wait_rel(60, k);
    chk(k == 15 && !glob, "R3 pin release N+3", k, 15);
  endtask

  task automatic t_sw_zero;
    wr(1'b0, 8'h00);
    repeat (10) @(negedge clk);
    chk(glob == 0, "R5 zero write ignored", glob, 0);
  endtask

  task automatic t_gate;
    int k;
    rails = 0; wr(1'b0, 8'h01);
    repeat (40) @(negedge clk);
    chk(glob == 1, "R2 held by rails", glob, 1);
    rails = 1; wait_rel(60, k);
    chk(k == 15, "R3 rails rise last", k, 15);
    clkst = 0; wr(1'b0, 8'h01);
    repeat (40) @(negedge clk);
    chk(glob == 1, "R2 held by clk_stable", glob, 1);
    clkst = 1; wait_rel(60, k);
    chk(k == 15, "R3 clk_stable rise last", k, 15);
  endtask

  task automatic t_drop;
    int k;
    wr(1'b0, 8'h01);
    repeat (8) @(negedge clk);
    rails = 0; repeat (4) @(negedge clk);
    chk(glob == 1, "R4 held during drop", glob, 1);
    rails = 1; wait_rel(60, k);
    chk(k == 15, "R4 count restarts", k, 15);
  endtask

  task automatic t_program;
    logic [7:0] v; int k;
    wr(1'b1, 8'd3);
    rd(1'b1, v); chk(v == 3, "R7 stall write", v, 3);
    wr(1'b0, 8'h01);
    chk(glob == 1, "R1 sw request asserts", glob, 1);
    rd(1'b0, v); chk(v == 1, "R6 busy during reset", v, 1);
    wait_rel(60, k);
    chk(k == 7, "R5 sw release N+4", k + 1, 8);
    rd(1'b0, v); chk(v == 0, "R6 busy cleared", v, 0);
  endtask

  task automatic t_lower;
    logic [7:0] v; int k;
    wr(1'b1, 8'd200);
    wr(1'b0, 8'h01);
    repeat (20) @(negedge clk);
    chk(glob == 1, "R3 long count running", glob, 1);
    wr(1'b1, 8'd2);
    chk(glob == 1, "R3 not yet released", glob, 1);
    rd(1'b0, v); chk(v == 1, "R6 busy before lowered release", v, 1);
    wait_rel(5, k);
    chk(k == 1 && !glob, "R3 lowered limit releases next edge", k, 1);
    rd(1'b0, v); chk(v == 0, "R6 busy cleared same edge", v, 0);
  endtask

  task automatic t_clk_stop;
    int k;
    wr(1'b0, 8'h01);
    repeat (2) @(negedge clk);
    clk_run = 0; #400;
    chk(glob == 1, "R9 no release without clock", glob, 1);
    clk_run = 1; wait_rel(40, k);
    chk(glob == 0, "R9 release after clock resumes", glob, 0);
  endtask

  task automatic t_qual_after;
    int k;
    @(negedge clk); clkst = 0; k = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); k++;
      if (glob) break;
    end
    chk(k == 3, "R4 reassert after release", k, 3);
    clkst = 1; wait_rel(40, k);
    chk(k == 5, "R4 restart with N=2", k, 5);
  endtask

  task automatic t_secure;
    logic [7:0] v; int k;
    @(negedge clk); #0.5 emu = 1; #0.5;
    chk(secure == 1, "R8 secure async set", secure, 1);
    chk(glob == 1, "R1 emu asserts async", glob, 1);
    @(negedge clk); emu = 0; wait_rel(40, k);
    chk(k == 5, "R3 emu release N=2", k, 5);
    chk(secure == 1, "R8 secure sticky", secure, 1);
    rd(1'b1, v); chk(v == 2, "R7 stall kept over emu", v, 2);
    wr(1'b0, 8'h01); wait_rel(40, k);
    chk(secure == 1, "R8 survives sw reset", secure, 1);
    @(negedge clk); #0.5 por_n = 0; #0.5;
    chk(secure == 0, "R8 pin clears secure", secure, 0);
    chk(glob == 1, "R1 pin asserts async", glob, 1);
    @(negedge clk); por_n = 1; wait_rel(40, k);
    chk(k == 15, "R7 pin restores default", k, 15);
    rd(1'b1, v); chk(v == 12, "R7 default after pin", v, 12);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    por_n = 0; emu = 0; rails = 1; clkst = 1;
    wr_valid = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    t_reset();
    t_por_release();
    t_sw_zero();
    t_gate();
    t_drop();
    t_program();
    t_lower();
    t_clk_stop();
    t_qual_after();
    t_secure();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule